// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides whether one physical memory access may proceed. It compares the access against a parameterised bank of protection entries. Each entry has an 8-bit configuration byte and an address register that holds bits [PA_W-1:2] of a byte address. An entry describes its region in one of three ways: as a top-of-range bound paired with the entry below it, as one naturally aligned 4-byte word, or as a naturally aligned power-of-two block. The entry's address mode selects which.

For every access the block takes the byte address, the access kind, the current privilege level and a machine-mode-lockdown enable. The lowest-numbered entry that matches is the one that decides. Its permission bits, its lock bit and the lockdown enable together give the verdict. When lockdown is on, some permission encodings that would otherwise be reserved mark regions shared between machine mode and the less privileged modes.

The logic is combinational. The match flag, the index of the matching entry and the verdict are registered once, so each result appears on the clock edge that follows the one sampling its inputs. Programming the entries and locking them belong to the surrounding logic.

Top module: `pmp_chk`

## Requirements
- R1: Entry k's configuration byte sits at cfg_i[8k+7:8k] and has this layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 address mode (0 off, 1 top-of-range, 2 single word, 3 power-of-two block), bits 6:5 ignored, bit 7 lock. An entry in mode 0 never matches.
- R2: In top-of-range mode, entry k matches byte addresses a with {reg[k-1],2'b00} <= a < {reg[k],2'b00}. Entry 0 uses 0 as its lower bound.
- R3: In single-word mode, entry k matches exactly the four bytes whose address bits [PA_W-1:2] equal reg[k].
- R4: In power-of-two mode, let n be the number of trailing one bits in reg[k]. The region is 8*2^n bytes, aligned to its size, and it contains {reg[k],2'b00}.
- R5: When several entries match, the lowest-numbered one sets the index and the verdict, even if a higher-numbered entry would grant the access.
- R6: When no entry matches, match is 0, the index is 0, and the access is allowed only in machine mode (priv 2'b11; 2'b01 is supervisor, 2'b00 is user).
- R7: With lockdown off, a matching entry allows a machine-mode access whenever lock is 0. In every other case it needs the permission bit for the access kind: load (type 0) needs read, store (type 1) needs write, fetch (type 2) needs execute.
- R8: With lockdown on and lock, read, write and execute all set, the entry allows loads in every privilege mode and denies stores and fetches.
- R9: With lockdown on, and for encodings other than the R8 one and other than read=0 with write=1, an access is allowed only when (priv is machine) equals lock and the permission bit for its kind is set.
- R10: With lockdown on, read=0, write=1, lock=0 and execute=1, loads and stores are allowed in every mode and fetches are denied.
- R11: With lockdown on, read=0, write=1, lock=0 and execute=0, loads are allowed in every mode, stores only in machine mode, and fetches never.
- R12: With lockdown on, read=0, write=1 and lock=1, fetches are allowed in every mode, loads only in machine mode and only when execute=1, and stores never.
- R13: Outputs are registered with one cycle of latency. While rst_ni is low, match_o, match_idx_o and allow_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 8*NUM_ENTRIES | Configuration bytes, one per entry |
| addr_reg_i | input | (PA_W-2)*NUM_ENTRIES | Address registers, one per entry |
| mml_i | input | 1 | Machine-mode lockdown enable |
| acc_addr_i | input | PA_W | Byte address of the access |
| acc_type_i | input | 2 | 0 load, 1 store, 2 fetch |
| priv_i | input | 2 | 3 machine, 1 supervisor, 0 user |
| match_o | output | 1 | Some entry matched |
| match_idx_o | output | $clog2(NUM_ENTRIES) | Index of the deciding entry |
| allow_o | output | 1 | Access permitted |

## Verification
The bench drives addresses one below, at and one past each top-of-range bound. A comparison off by one would either let the first byte of the next region in or lock the last word out. It places power-of-two regions with zero and with two trailing ones and probes both ends of each, because a mask error changes the region size or its alignment. It overlaps a deny-all word with a wider permissive block to catch a priority picker that favours the higher index. It then walks every lockdown encoding, the shared ones included, across machine and user mode and all three access kinds. An inverted lock comparison or a swapped shared-region case shows up there as a wrong verdict.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_WORD  = 2'd2,
    AM_BLOCK = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  localparam logic [1:0] PRIV_M = 2'b11;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    amode_e     mode;
    logic       x;
    logic       w;
    logic       r;
  } ent_cfg_t;

endpackage

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
  import pmp_chk_pkg::*;
#(
  parameter int PA_W = 32,
  localparam int RW  = PA_W - 2
) (
  input  amode_e          mode_i,
  input  logic [RW-1:0]   reg_i,
  input  logic [RW-1:0]   prev_reg_i,
  input  logic [PA_W-1:0] addr_i,
  output logic            hit_o
);

  logic [PA_W-1:0] top_b, bot_b, blk_mask;
  logic [RW-1:0]   ones_src, low_ones;
  logic            tor_hit, word_hit, blk_hit;

  assign top_b = {reg_i, 2'b00};
  assign bot_b = {prev_reg_i, 2'b00};
  assign tor_hit  = (addr_i >= bot_b) && (addr_i < top_b);
  assign word_hit = (addr_i[PA_W-1:2] == reg_i);

  // trailing-ones run of {reg,1} marks the don't-care bits
  assign ones_src = {reg_i[RW-2:0], 1'b1};
  assign low_ones = ones_src & ~(ones_src + 1'b1);
  assign blk_mask = {~low_ones, 2'b00};
  assign blk_hit  = ((addr_i ^ top_b) & blk_mask) == '0;

  always_comb begin
    unique case (mode_i)
      AM_TOR:   hit_o = tor_hit;
      AM_WORD:  hit_o = word_hit;
      AM_BLOCK: hit_o = blk_hit;
      default:  hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_prio_pick.sv
module pmp_prio_pick #(
  parameter int  NUM_ENTRIES = 8,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] hit_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o
);

  always_comb begin
    idx_o = '0;
    for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
      if (hit_i[k]) idx_o = IDX_W'(k);
    end
  end

  assign any_o = |hit_i;

endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
  import pmp_chk_pkg::*;
(
  input  ent_cfg_t   cfg_i,
  input  logic [1:0] acc_type_i,
  input  logic       is_m_i,
  input  logic       mml_i,
  output logic       ok_o
);

  logic ld, st, fe, bit_ok, shared_enc, all_set;

  assign ld = (acc_type_i == ACC_LOAD);
  assign st = (acc_type_i == ACC_STORE);
  assign fe = (acc_type_i == ACC_FETCH);
  assign bit_ok     = (ld & cfg_i.r) | (st & cfg_i.w) | (fe & cfg_i.x);
  assign shared_enc = ~cfg_i.r & cfg_i.w;
  assign all_set    = cfg_i.lock & cfg_i.r & cfg_i.w & cfg_i.x;

  always_comb begin
    if (!mml_i) begin
      ok_o = (is_m_i & ~cfg_i.lock) | bit_ok;
    end else if (all_set) begin
      ok_o = ld;
    end else if (shared_enc) begin
      if (!cfg_i.lock) ok_o = cfg_i.x ? (ld | st) : (ld | (st & is_m_i));
      else             ok_o = fe | (ld & cfg_i.x & is_m_i);
    end else begin
      ok_o = (is_m_i == cfg_i.lock) & bit_ok;
    end
  end

endmodule

// File: rtl/pmp_chk.sv
module pmp_chk
  import pmp_chk_pkg::*;
#(
  parameter int  NUM_ENTRIES = 8,
  parameter int  PA_W        = 32,
  localparam int RW          = PA_W - 2,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [8*NUM_ENTRIES-1:0]  cfg_i,
  input  logic [RW*NUM_ENTRIES-1:0] addr_reg_i,
  input  logic                      mml_i,
  input  logic [PA_W-1:0]           acc_addr_i,
  input  logic [1:0]                acc_type_i,
  input  logic [1:0]                priv_i,
  output logic                      match_o,
  output logic [IDX_W-1:0]          match_idx_o,
  output logic                      allow_o
);

  ent_cfg_t                cfg_a [NUM_ENTRIES];
  logic [RW-1:0]           reg_a [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]  hit;
  logic [2*NUM_ENTRIES-1:0] rsvd_bits;
  logic                    unused_rsvd;
  logic                    any_hit, sel_ok, is_m, allow_d;
  logic [IDX_W-1:0]        sel_idx;
  ent_cfg_t                sel_cfg;

  assign is_m = (priv_i == PRIV_M);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic [RW-1:0] prev_reg;
    assign cfg_a[i] = ent_cfg_t'(cfg_i[8*i +: 8]);
    assign reg_a[i] = addr_reg_i[RW*i +: RW];
    assign rsvd_bits[2*i +: 2] = cfg_a[i].rsvd;
    if (i == 0) begin : g_first
      assign prev_reg = '0;
    end else begin : g_rest
      assign prev_reg = addr_reg_i[RW*(i-1) +: RW];
    end
    pmp_entry_match #(.PA_W(PA_W)) u_match (
      .mode_i     (cfg_a[i].mode),
      .reg_i      (reg_a[i]),
      .prev_reg_i (prev_reg),
      .addr_i     (acc_addr_i),
      .hit_o      (hit[i])
    );
  end

  assign unused_rsvd = ^rsvd_bits;

  pmp_prio_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
    .hit_i (hit),
    .any_o (any_hit),
    .idx_o (sel_idx)
  );

  assign sel_cfg = cfg_a[sel_idx];

  pmp_perm_eval u_perm (
    .cfg_i      (sel_cfg),
    .acc_type_i (acc_type_i),
    .is_m_i     (is_m),
    .mml_i      (mml_i),
    .ok_o       (sel_ok)
  );

  assign allow_d = any_hit ? sel_ok : is_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o     <= 1'b0;
      match_idx_o <= '0;
      allow_o     <= 1'b0;
    end else begin
      match_o     <= any_hit;
      match_idx_o <= sel_idx;
      allow_o     <= allow_d;
    end
  end

endmodule

// File: rtl/pmp_chk_sva.sv
module pmp_chk_sva
  import pmp_chk_pkg::*;
#(
  parameter int  NUM_ENTRIES = 8,
  parameter int  PA_W        = 32,
  localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [8*NUM_ENTRIES-1:0] cfg_i,
  input logic                     mml_i,
  input logic [1:0]               acc_type_i,
  input logic [1:0]               priv_i,
  input logic                     match_o,
  input logic [IDX_W-1:0]         match_idx_o,
  input logic                     allow_o
);

  logic [8*NUM_ENTRIES-1:0] cfg_q;
  logic                     mml_q, seen_q;
  logic [1:0]               type_q, priv_q;
  logic [7:0]               sel;
  logic                     all_off, m_q;
  logic                     unused_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mml_q  <= 1'b0;
      type_q <= '0;
      priv_q <= '0;
      seen_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_i;
      mml_q  <= mml_i;
      type_q <= acc_type_i;
      priv_q <= priv_i;
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    all_off = 1'b1;
    for (int k = 0; k < NUM_ENTRIES; k++)
      if (cfg_q[8*k+3 +: 2] != 2'b00) all_off = 1'b0;
  end

  assign sel        = cfg_q[8*match_idx_o +: 8];
  assign unused_sel = ^sel[6:3];
  assign m_q        = (priv_q == PRIV_M);

  p_off_no_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && all_off) |-> !match_o);

  p_miss_priv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !match_o) |-> (allow_o == m_q));

  p_m_unlocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && match_o && !mml_q && m_q && !sel[7]) |-> allow_o);

  p_locked_ro_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && match_o && mml_q && (sel[7] && sel[2:0] == 3'b111))
      |-> (allow_o == (type_q == ACC_LOAD)));

  p_lock_side_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && match_o && mml_q && !(sel[1:0] == 2'b10)
     && !(sel[7] && sel[2:0] == 3'b111) && (m_q != sel[7])) |-> !allow_o);

  p_shared_fetch_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && match_o && mml_q && sel[7] && sel[1:0] == 2'b10
     && type_q == ACC_FETCH) |-> allow_o);

endmodule

bind pmp_chk pmp_chk_sva #(.NUM_ENTRIES(NUM_ENTRIES), .PA_W(PA_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_i       (cfg_i),
  .mml_i       (mml_i),
  .acc_type_i  (acc_type_i),
  .priv_i      (priv_i),
  .match_o     (match_o),
  .match_idx_o (match_idx_o),
  .allow_o     (allow_o)
);

// File: tb/pmp_chk_bench.sv
module pmp_chk_bench;

  localparam int N  = 8;
  localparam int PA = 32;
  localparam int RW = PA - 2;

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2;
  localparam logic [1:0] PM = 2'b11, PS = 2'b01, PU = 2'b00;
  // cfg bytes: L bit7, mode 4:3, X W R 2:0
  localparam logic [7:0] C_TOR = 8'h08, C_WORD = 8'h10, C_BLK = 8'h18;
  localparam logic [7:0] B_R = 8'h01, B_W = 8'h02, B_X = 8'h04, B_L = 8'h80;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [8*N-1:0]    cfg_flat = '0;
  logic [RW*N-1:0]   reg_flat = '0;
  logic              mml = 1'b0;
  logic [PA-1:0]     addr = '0;
  logic [1:0]        atype = '0;
  logic [1:0]        priv = '0;
  logic              match_o, allow_o;
  logic [2:0]        idx_o;

  logic [7:0]        cfg_b [N];
  logic [RW-1:0]     reg_b [N];

  typedef struct {
    string      tag;
    logic       m;
    logic [2:0] idx;
    logic       al;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;

  always #5 clk = ~clk;

  pmp_chk #(.NUM_ENTRIES(N), .PA_W(PA)) u_pmp_chk (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_i       (cfg_flat),
    .addr_reg_i  (reg_flat),
    .mml_i       (mml),
    .acc_addr_i  (addr),
    .acc_type_i  (atype),
    .priv_i      (priv),
    .match_o     (match_o),
    .match_idx_o (idx_o),
    .allow_o     (allow_o)
  );

  function automatic logic hit_of(int i, logic [PA-1:0] a);
    logic [63:0] lo, hi, sz, base;
    int n;
    case (cfg_b[i][4:3])
      2'd1: begin
        lo = (i == 0) ? 64'd0 : {32'd0, reg_b[i-1], 2'b00};
        hi = {32'd0, reg_b[i], 2'b00};
        return ({32'd0, a} >= lo) && ({32'd0, a} < hi);
      end
      2'd2: return a[PA-1:2] == reg_b[i];
      2'd3: begin
        n = 0;
        while (n < RW && reg_b[i][n]) n++;
        sz   = 64'd8 << n;
        base = {32'd0, reg_b[i], 2'b00} & ~(sz - 64'd1);
        return ({32'd0, a} >= base) && ({32'd0, a} < base + sz);
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic perm_of(logic [7:0] c, logic [1:0] t, logic [1:0] p, logic lk);
    logic r, w, x, l, m, need;
    r = c[0]; w = c[1]; x = c[2]; l = c[7]; m = (p == PM);
    need = (t == LD) ? r : (t == ST) ? w : x;
    if (!lk) return (m && !l) || need;
    if (l && r && w && x) return t == LD;
    if (!r && w) begin
      if (!l && x)  return (t == LD) || (t == ST);
      if (!l && !x) return (t == LD) || (t == ST && m);
      return (t == FE) || (t == LD && x && m);
    end
    return (m == l) && need;
  endfunction

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      cfg_b[i] = '0;
      reg_b[i] = '0;
    end
  endtask

  task automatic put(int i, logic [7:0] c, logic [RW-1:0] r);
    cfg_b[i] = c;
    reg_b[i] = r;
  endtask

  task automatic acc(string tag, logic [PA-1:0] a, logic [1:0] t, logic [1:0] p, logic lk);
    exp_t e;
    int   first;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      cfg_flat[8*i +: 8]   = cfg_b[i];
      reg_flat[RW*i +: RW] = reg_b[i];
    end
    addr = a; atype = t; priv = p; mml = lk;
    first = -1;
    for (int i = N - 1; i >= 0; i--) if (hit_of(i, a)) first = i;
    e.tag = tag;
    e.m   = (first >= 0);
    e.idx = (first >= 0) ? 3'(first) : 3'd0;
    e.al  = (first >= 0) ? perm_of(cfg_b[first], t, p, lk) : (p == PM);
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (match_o !== e.m || idx_o !== e.idx || allow_o !== e.al) begin
        n_err++;
        $display("FAIL %s: got m=%0b idx=%0d allow=%0b, want m=%0b idx=%0d allow=%0b",
                 e.tag, match_o, idx_o, allow_o, e.m, e.idx, e.al);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got hang, want completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    clear_all();
    #23;
    n_chk++;
    if (match_o !== 1'b0 || idx_o !== 3'd0 || allow_o !== 1'b0) begin
      n_err++;
      $display("FAIL R13 reset: got %0b/%0d/%0b want 0/0/0", match_o, idx_o, allow_o);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R6: all entries off
    acc("R1 off M", 32'h100, LD, PM, 0);
    acc("R6 miss U", 32'h100, LD, PU, 0);
    acc("R6 miss S", 32'h100, FE, PS, 1);

    // R2: top-of-range
    clear_all();
    put(0, C_TOR | B_R, 30'h100);
    put(1, C_TOR | B_R | B_W, 30'h200);
    acc("R2 e0 last word", 32'h3FC, LD, PU, 0);
    acc("R2 e0 base", 32'h0, LD, PU, 0);
    acc("R7 e0 store deny", 32'h3FC, ST, PU, 0);
    acc("R2 e1 first byte", 32'h400, ST, PU, 0);
    acc("R2 e1 last byte", 32'h7FF, LD, PS, 0);
    acc("R2 past top", 32'h800, LD, PU, 0);

    // R3: single word
    clear_all();
    put(2, C_WORD | B_X, 30'h1000);
    acc("R3 word lo", 32'h4000, FE, PU, 0);
    acc("R3 word hi", 32'h4003, FE, PU, 0);
    acc("R3 next word", 32'h4004, FE, PU, 0);
    acc("R3 prev word", 32'h3FFC, FE, PM, 0);

    // R4: power-of-two block
    clear_all();
    put(3, C_BLK | B_R, 30'h2003);
    acc("R4 32B base", 32'h8000, LD, PU, 0);
    acc("R4 32B end", 32'h801F, LD, PU, 0);
    acc("R4 32B past", 32'h8020, LD, PU, 0);
    acc("R4 32B below", 32'h7FFC, LD, PU, 0);
    put(3, C_BLK | B_R, 30'h2000);
    acc("R4 8B end", 32'h8007, LD, PU, 0);
    acc("R4 8B past", 32'h8008, LD, PU, 0);

    // R5: priority
    clear_all();
    put(0, C_WORD, 30'h1400);
    put(1, C_BLK | B_R | B_W | B_X, 30'h13FF);
    acc("R5 low idx wins", 32'h5000, LD, PU, 0);
    acc("R5 high idx alone", 32'h5004, LD, PU, 0);

    // R7: lockdown off
    clear_all();
    put(0, C_WORD, 30'h40);
    acc("R7 M unlocked", 32'h100, ST, PM, 0);
    put(0, C_WORD | B_L, 30'h40);
    acc("R7 M locked none", 32'h100, ST, PM, 0);
    put(0, C_WORD | B_L | B_R, 30'h40);
    acc("R7 M locked R ld", 32'h100, LD, PM, 0);
    acc("R7 M locked R st", 32'h100, ST, PM, 0);

    // R8: locked read-only shared
    put(0, C_WORD | B_L | B_R | B_W | B_X, 30'h40);
    acc("R8 U load", 32'h100, LD, PU, 1);
    acc("R8 M store", 32'h100, ST, PM, 1);
    acc("R8 S fetch", 32'h100, FE, PS, 1);

    // R9: lockdown non-shared
    put(0, C_WORD | B_R, 30'h40);
    acc("R9 U load L0", 32'h100, LD, PU, 1);
    acc("R9 M load L0", 32'h100, LD, PM, 1);
    put(0, C_WORD | B_L | B_X, 30'h40);
    acc("R9 M fetch L1", 32'h100, FE, PM, 1);
    acc("R9 U fetch L1", 32'h100, FE, PU, 1);

    // R10
    put(0, C_WORD | B_W | B_X, 30'h40);
    acc("R10 U load", 32'h100, LD, PU, 1);
    acc("R10 M store", 32'h100, ST, PM, 1);
    acc("R10 U fetch", 32'h100, FE, PU, 1);

    // R11
    put(0, C_WORD | B_W, 30'h40);
    acc("R11 U load", 32'h100, LD, PU, 1);
    acc("R11 U store", 32'h100, ST, PU, 1);
    acc("R11 M store", 32'h100, ST, PM, 1);

    // R12
    put(0, C_WORD | B_L | B_W | B_X, 30'h40);
    acc("R12 U fetch", 32'h100, FE, PU, 1);
    acc("R12 M load X1", 32'h100, LD, PM, 1);
    acc("R12 U load X1", 32'h100, LD, PU, 1);
    put(0, C_WORD | B_L | B_W, 30'h40);
    acc("R12 M load X0", 32'h100, LD, PM, 1);
    acc("R12 S fetch X0", 32'h100, FE, PS, 1);
    acc("R12 M store", 32'h100, ST, PM, 1);

    repeat (3) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_err++;
      $display("FAIL R13 drain: got %0d pending want 0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule